// File: doc/BRIEF.md
# Programmable-Order Decimating CIC Filter

This block lowers the sample rate of a two-lane (in-phase and quadrature) stream of 24-bit signed samples with a cascaded integrator-comb filter. Software picks three settings at run time: how many integrator/comb stage pairs take part (zero to five), the decimation ratio R (four to 65536), and a left shift applied to each sample before it enters the integrators. The filter gain is R to the power N, where N is the number of stages. The shift is chosen so that 2^shift times R^N lies between 2^44 and 2^45. The output, the top 24 bits of a 69-bit result, then carries a gain between one half and one.

Samples are qualified by a valid input, and only qualified samples count towards the decimation ratio. After every R-th qualified sample, one filtered result per lane appears with a one-cycle valid strobe. With zero stages the block passes every R-th sample on, scaled only by the shift. A change to the stage count or the decimation ratio clears all filter and counter state, so the filter restarts cleanly.

Top module: `prog_cic_decimator`

## Requirements
- R1: After reset, out_valid is 0 and out_i and out_q are 0.
- R2: With cfg_order = 0, the output after each R-th accepted sample is that sample shifted left by the effective shift, kept as a 69-bit signed value, of which the top 24 bits are taken (an arithmetic shift right by 45 minus the shift, which rounds toward minus infinity).
- R3: out_valid pulses high for exactly one cycle per R accepted samples. It goes high in the second cycle after the clock edge that accepts the R-th sample. Cycles with in_valid low do not count.
- R4: With N = cfg_order stages (1 to 5) and a constant input x, every output from the (N+1)-th onward after a clear equals floor(x * R^N * 2^shift / 2^45). This holds up to R = 512 with N = 5 and full-scale inputs, because the integrators wrap modulo 2^69.
- R5: A cfg_order value above 5 behaves exactly as 5.
- R6: The ratio is R = cfg_dec + 1. A cfg_dec value below 3 behaves as 3 (R = 4).
- R7: A cfg_shift value above 45 behaves as 45.
- R8: A change in the effective stage count or the effective ratio clears all integrator, comb, decimation-counter and in-flight output state. The next output then reflects only samples accepted after the change.
- R9: A sample presented with in_valid in the same cycle as a configuration change is discarded and is not counted.
- R10: The in-phase and quadrature lanes are filtered identically and independently and share one valid strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_i and in_q |
| in_i | input | 24 | In-phase input sample, two's complement |
| in_q | input | 24 | Quadrature input sample, two's complement |
| cfg_order | input | 3 | Number of active stage pairs, 0 to 5 |
| cfg_dec | input | 16 | Decimation ratio minus one |
| cfg_shift | input | 6 | Left shift applied before the integrators |
| out_valid | output | 1 | One-cycle strobe for a decimated result |
| out_i | output | 24 | Decimated in-phase result |
| out_q | output | 24 | Decimated quadrature result |

## Verification
Two functions can fall in the same cycle: the clear that a configuration change causes, and the acceptance of a valid sample. The bench changes the stage count in the same cycle as it presents a sample with a distinct marker value, after earlier traffic has left the integrators and the counter partly filled. It judges the result from when the first output appears and from its value: that output must arrive after exactly R further samples and must equal the zero-state response of the new order to those samples alone. Either a leaked old state or a counted marker sample would change the timing or the value.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int unsigned CIC_IN_W      = 24;
    localparam int unsigned CIC_MAX_ORDER = 5;
    localparam int unsigned CIC_GROWTH    = 9;
    localparam int unsigned CIC_ACC_W     = CIC_IN_W + CIC_MAX_ORDER * CIC_GROWTH;
    localparam int unsigned CIC_MAX_SHIFT = CIC_ACC_W - CIC_IN_W;
    localparam int unsigned CIC_CNT_W     = 16;
    localparam int unsigned CIC_ORD_W     = 3;
    localparam int unsigned CIC_SH_W      = 6;
    localparam int unsigned CIC_MIN_RM1   = 3;
    localparam int unsigned CIC_LANES     = 2;

    typedef struct packed {
        logic [CIC_ORD_W-1:0] order;
        logic [CIC_CNT_W-1:0] r_m1;
        logic [CIC_SH_W-1:0]  shift;
    } cic_cfg_t;

    // Clamp raw settings into the supported range.
    function automatic cic_cfg_t cic_sanitize(
        input logic [CIC_ORD_W-1:0] order,
        input logic [CIC_CNT_W-1:0] dec,
        input logic [CIC_SH_W-1:0]  shift
    );
        cic_cfg_t res;
        res.order = (order > CIC_ORD_W'(CIC_MAX_ORDER)) ? CIC_ORD_W'(CIC_MAX_ORDER) : order;
        res.r_m1  = (dec < CIC_CNT_W'(CIC_MIN_RM1)) ? CIC_CNT_W'(CIC_MIN_RM1) : dec;
        res.shift = (shift > CIC_SH_W'(CIC_MAX_SHIFT)) ? CIC_SH_W'(CIC_MAX_SHIFT) : shift;
        return res;
    endfunction

endpackage

// File: rtl/cic_integrator_chain.sv
module cic_integrator_chain #(
    parameter int unsigned IN_W      = cic_pkg::CIC_IN_W,
    parameter int unsigned ACC_W     = cic_pkg::CIC_ACC_W,
    parameter int unsigned MAX_ORDER = cic_pkg::CIC_MAX_ORDER,
    parameter int unsigned ORD_W     = cic_pkg::CIC_ORD_W,
    parameter int unsigned SH_W      = cic_pkg::CIC_SH_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    smp_valid,
    input  logic signed [IN_W-1:0]  smp_data,
    input  logic [ORD_W-1:0]        order,
    input  logic [SH_W-1:0]         shift,
    output logic signed [ACC_W-1:0] chain_out
);

    logic signed [ACC_W-1:0] widened;
    logic signed [ACC_W-1:0] scaled;

    assign widened = {{(ACC_W-IN_W){smp_data[IN_W-1]}}, smp_data};
    assign scaled  = widened <<< shift;

    for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
        logic signed [ACC_W-1:0] stage_in;
        logic signed [ACC_W-1:0] stage_out;
        logic signed [ACC_W-1:0] total;
        logic signed [ACC_W-1:0] acc_q;
        logic                    active;

        if (k == 0) begin : g_head
            assign stage_in = scaled;
        end else begin : g_link
            assign stage_in = g_stage[k-1].stage_out;
        end

        assign active    = (ORD_W'(k) < order);
        assign total     = acc_q + stage_in;   // modular wrap is intended
        assign stage_out = active ? total : stage_in;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                acc_q <= '0;
            end else if (smp_valid && active) begin
                acc_q <= total;
            end
        end

        // R5/R8: a bypassed stage keeps no state
        p_idle_integ_zero_r5: assert property (@(posedge clk) disable iff (rst || clr)
            !active |-> (acc_q == '0))
            else $error("bypassed integrator holds state");
    end

    assign chain_out = g_stage[MAX_ORDER-1].stage_out;

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int unsigned ACC_W     = cic_pkg::CIC_ACC_W,
    parameter int unsigned OUT_W     = cic_pkg::CIC_IN_W,
    parameter int unsigned MAX_ORDER = cic_pkg::CIC_MAX_ORDER,
    parameter int unsigned ORD_W     = cic_pkg::CIC_ORD_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    dec_valid,
    input  logic signed [ACC_W-1:0] dec_data,
    input  logic [ORD_W-1:0]        order,
    output logic                    res_valid,
    output logic [OUT_W-1:0]        res_data
);

    for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
        logic signed [ACC_W-1:0] stage_in;
        logic signed [ACC_W-1:0] stage_out;
        logic signed [ACC_W-1:0] diff;
        logic signed [ACC_W-1:0] dly_q;
        logic                    active;

        if (k == 0) begin : g_head
            assign stage_in = dec_data;
        end else begin : g_link
            assign stage_in = g_stage[k-1].stage_out;
        end

        assign active    = (ORD_W'(k) < order);
        assign diff      = stage_in - dly_q;
        assign stage_out = active ? diff : stage_in;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                dly_q <= '0;
            end else if (dec_valid && active) begin
                dly_q <= stage_in;
            end
        end

        // R5/R8: a bypassed comb keeps no state
        p_idle_comb_zero_r5: assert property (@(posedge clk) disable iff (rst || clr)
            !active |-> (dly_q == '0))
            else $error("bypassed comb holds state");
    end

    logic signed [ACC_W-1:0] final_sum;
    assign final_sum = g_stage[MAX_ORDER-1].stage_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else if (clr) begin
            res_valid <= 1'b0;
        end else begin
            res_valid <= dec_valid;
            if (dec_valid) begin
                res_data <= final_sum[ACC_W-1 -: OUT_W];
            end
        end
    end

endmodule

// File: rtl/cic_decim_counter.sv
module cic_decim_counter #(
    parameter int unsigned CNT_W = cic_pkg::CIC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             smp_valid,
    input  logic [CNT_W-1:0] r_m1,
    output logic             dec_stb
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == r_m1);
    assign dec_stb = smp_valid && at_last && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (smp_valid) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R6: the phase counter never passes the effective ratio
    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst || clr)
        cnt_q <= r_m1)
        else $error("decimation counter out of range");

    // R3: an idle input cycle never advances the phase
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst || clr)
        !smp_valid |=> $stable(cnt_q))
        else $error("counter moved without a sample");

endmodule

// File: rtl/prog_cic_decimator.sv
module prog_cic_decimator
    import cic_pkg::*;
#(
    parameter int unsigned IN_W      = CIC_IN_W,
    parameter int unsigned ACC_W     = CIC_ACC_W,
    parameter int unsigned MAX_ORDER = CIC_MAX_ORDER,
    parameter int unsigned ORD_W     = CIC_ORD_W,
    parameter int unsigned CNT_W     = CIC_CNT_W,
    parameter int unsigned SH_W      = CIC_SH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_i,
    input  logic [IN_W-1:0]  in_q,
    input  logic [ORD_W-1:0] cfg_order,
    input  logic [CNT_W-1:0] cfg_dec,
    input  logic [SH_W-1:0]  cfg_shift,
    output logic             out_valid,
    output logic [IN_W-1:0]  out_i,
    output logic [IN_W-1:0]  out_q
);

    localparam int unsigned LANES = CIC_LANES;

    cic_cfg_t         cfg_eff;
    logic [ORD_W-1:0] order_q;
    logic [CNT_W-1:0] r_m1_q;
    logic             cfg_chg;
    logic             smp_ok;
    logic             dec_stb;
    logic             dec_v_q;

    logic [LANES-1:0][IN_W-1:0] lane_in;
    logic [LANES-1:0][IN_W-1:0] lane_out;
    logic [LANES-1:0]           lane_vld;

    assign cfg_eff = cic_sanitize(cfg_order, cfg_dec, cfg_shift);
    assign cfg_chg = (cfg_eff.order != order_q) || (cfg_eff.r_m1 != r_m1_q);
    assign smp_ok  = in_valid && !cfg_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            order_q <= '0;
            r_m1_q  <= CNT_W'(CIC_MIN_RM1);
        end else begin
            order_q <= cfg_eff.order;
            r_m1_q  <= cfg_eff.r_m1;
        end
    end

    cic_decim_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .clr       (cfg_chg),
        .smp_valid (smp_ok),
        .r_m1      (cfg_eff.r_m1),
        .dec_stb   (dec_stb)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_chg) begin
            dec_v_q <= 1'b0;
        end else begin
            dec_v_q <= dec_stb;
        end
    end

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic signed [ACC_W-1:0] integ_sum;
        logic signed [ACC_W-1:0] dec_q;

        cic_integrator_chain #(
            .IN_W(IN_W), .ACC_W(ACC_W), .MAX_ORDER(MAX_ORDER),
            .ORD_W(ORD_W), .SH_W(SH_W)
        ) u_integ (
            .clk       (clk),
            .rst       (rst),
            .clr       (cfg_chg),
            .smp_valid (smp_ok),
            .smp_data  (lane_in[ln]),
            .order     (cfg_eff.order),
            .shift     (cfg_eff.shift),
            .chain_out (integ_sum)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                dec_q <= '0;
            end else if (dec_stb) begin
                dec_q <= integ_sum;
            end
        end

        cic_comb_chain #(
            .ACC_W(ACC_W), .OUT_W(IN_W), .MAX_ORDER(MAX_ORDER), .ORD_W(ORD_W)
        ) u_comb (
            .clk       (clk),
            .rst       (rst),
            .clr       (cfg_chg),
            .dec_valid (dec_v_q),
            .dec_data  (dec_q),
            .order     (cfg_eff.order),
            .res_valid (lane_vld[ln]),
            .res_data  (lane_out[ln])
        );
    end

    assign out_valid = &lane_vld;
    assign out_i     = lane_out[0];
    assign out_q     = lane_out[1];

    // R3: a result strobe never lasts two cycles (R is at least four)
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid)
        else $error("output strobe held high");

    // R8: a configuration change flushes the in-flight result
    p_change_flush_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_chg |=> ##1 !out_valid)
        else $error("result emerged across a configuration change");

    // R10: both lanes strobe together
    p_lanes_aligned_r10: assert property (@(posedge clk) disable iff (rst)
        (lane_vld == '0) || (lane_vld == '1))
        else $error("lane strobes disagree");

endmodule

// File: tb/prog_cic_decimator_tb_top.sv
`timescale 1ns/1ps
module prog_cic_decimator_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_i = '0;
    logic [23:0] in_q = '0;
    logic [2:0]  cfg_order = '0;
    logic [15:0] cfg_dec = 16'd3;
    logic [5:0]  cfg_shift = '0;
    logic        out_valid;
    logic [23:0] out_i;
    logic [23:0] out_q;

    int checks = 0;
    int failures = 0;

    logic signed [23:0] got_i[$];
    logic signed [23:0] got_q[$];

    always #2 clk = ~clk;

    prog_cic_decimator dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cfg_order(cfg_order), .cfg_dec(cfg_dec), .cfg_shift(cfg_shift),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            got_i.push_back(out_i);
            got_q.push_back(out_q);
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_case(input logic [2:0] ord, input logic [15:0] dec,
                              input logic [5:0] sh);
        rst = 1'b1;
        in_valid = 1'b0;
        cfg_order = ord;
        cfg_dec = dec;
        cfg_shift = sh;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        got_i.delete();
        got_q.delete();
    endtask

    task automatic drive(input longint xi, input longint xq);
        in_valid = 1'b1;
        in_i = 24'(xi);
        in_q = 24'(xq);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drive_const(input int n, input longint xi, input longint xq);
        for (int s = 0; s < n; s++) drive(xi, xq);
    endtask

    task automatic drain();
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 out_i", longint'(out_i), 0);
        check("R1 out_q", longint'(out_q), 0);
        rst = 1'b0;
    endtask

    // R2, R10: order 0 picks every R-th sample
    task automatic t_order0_pick();
        start_case(3'd0, 16'd4, 6'd45);
        for (int s = 0; s < 10; s++) drive(s * 3 - 50, -s * 7);
        drain();
        check("R2 count", got_i.size(), 2);
        if (got_i.size() == 2) begin
            check("R2 first i", got_i[0], 4 * 3 - 50);
            check("R10 first q", got_q[0], -4 * 7);
            check("R2 second i", got_i[1], 9 * 3 - 50);
            check("R10 second q", got_q[1], -9 * 7);
        end
    endtask

    // R2: partial shift truncates toward minus infinity
    task automatic t_order0_shift();
        start_case(3'd0, 16'd3, 6'd40);
        drive_const(4, -100, 100);
        drain();
        check("R2 shift count", got_i.size(), 1);
        if (got_i.size() == 1) begin
            check("R2 floor i", got_i[0], -4);
            check("R2 floor q", got_q[0], 3);
        end
    endtask

    // R3: strobe timing with idle gaps
    task automatic t_timing();
        start_case(3'd1, 16'd3, 6'd43);
        for (int s = 0; s < 3; s++) begin
            drive(5, -9);
            check("R3 no early strobe", longint'(out_valid), 0);
            @(negedge clk);
            check("R3 no early strobe gap", longint'(out_valid), 0);
        end
        drive(5, -9);
        check("R3 one cycle after", longint'(out_valid), 0);
        @(negedge clk);
        check("R3 two cycles after", longint'(out_valid), 1);
        check("R4 order1 i", longint'($signed(out_i)), 5);
        check("R4 order1 q", longint'($signed(out_q)), -9);
        @(negedge clk);
        check("R3 strobe single", longint'(out_valid), 0);
    endtask

    // R4: steady-state gain for several orders
    task automatic t_gain(input int n, input int r, input logic [5:0] sh,
                          input longint xi, input longint xq,
                          input longint ei, input longint eq);
        start_case(3'(n), 16'(r - 1), sh);
        drive_const((n + 2) * r, xi, xq);
        drain();
        check("R4 gain count", got_i.size(), n + 2);
        if (got_i.size() == n + 2) begin
            check("R4 gain i", got_i[n + 1], ei);
            check("R4 gain q", got_q[n + 1], eq);
        end
    endtask

    // R5: order above 5 acts as 5
    task automatic t_order_clamp();
        start_case(3'd7, 16'd15, 6'd25);
        drive_const(7 * 16, 777, -333);
        drain();
        check("R5 clamp count", got_i.size(), 7);
        if (got_i.size() == 7) begin
            check("R5 clamp i", got_i[6], 777);
            check("R5 clamp q", got_q[6], -333);
        end
    endtask

    // R6: ratio floor of four
    task automatic t_dec_floor();
        start_case(3'd0, 16'd0, 6'd45);
        for (int s = 0; s < 8; s++) drive(s + 100, s - 100);
        drain();
        check("R6 floor count", got_i.size(), 2);
        if (got_i.size() == 2) begin
            check("R6 floor first", got_i[0], 103);
            check("R6 floor second", got_q[1], -93);
        end
    endtask

    // R7: shift above 45 acts as 45
    task automatic t_shift_clamp();
        start_case(3'd0, 16'd3, 6'd63);
        drive_const(4, 1234, -4321);
        drain();
        check("R7 clamp count", got_i.size(), 1);
        if (got_i.size() == 1) begin
            check("R7 clamp i", got_i[0], 1234);
            check("R7 clamp q", got_q[0], -4321);
        end
    endtask

    // R8, R9: change coinciding with a valid sample
    task automatic t_cfg_change();
        start_case(3'd1, 16'd3, 6'd43);
        drive_const(6, 999, -999);
        drain();
        check("R8 pre-change count", got_i.size(), 1);
        got_i.delete();
        got_q.delete();
        cfg_order = 3'd2;
        cfg_shift = 6'd41;
        drive(5555, 7777);
        drive_const(3, 1600, 3200);
        @(negedge clk);
        @(negedge clk);
        check("R9 marker not counted", got_i.size(), 0);
        drive(1600, 3200);
        drain();
        check("R9 one output after R samples", got_i.size(), 1);
        if (got_i.size() == 1) begin
            check("R8 zero-state i", got_i[0], 1000);
            check("R8 zero-state q", got_q[0], 2000);
        end
        drive_const(4, 1600, 3200);
        drain();
        check("R8 second count", got_i.size(), 2);
        if (got_i.size() == 2) begin
            check("R8 steady i", got_i[1], 1600);
            check("R8 steady q", got_q[1], 3200);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_order0_pick();
        t_order0_shift();
        t_timing();
        t_gain(3, 8, 6'd36, 123456, -7654321, 123456, -7654321);
        t_gain(5, 16, 6'd25, -8388608, 8388607, -8388608, 8388607);
        t_gain(2, 6, 6'd39, 1000000, -1000, 562500, -563);
        t_gain(5, 512, 6'd0, -8388608, 8388607, -8388608, 8388607);
        t_order_clamp();
        t_dec_floor();
        t_shift_clamp();
        t_cfg_change();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule